// File: doc/BRIEF.md
# Fault Alert Hold Timer

This block produces the active-low alert outputs of a multi-channel supply and temperature supervisor. One alert reports undervoltage. It looks at a vector of per-channel flags, where a 1 means that the voltage input is below its threshold. The second alert reports overtemperature when the mode input is high. It compares an unsigned temperature reading against a limit and uses a hysteresis value for the release point.

An alert goes low in the same cycle that a fault appears. It returns high only after its fault condition has stayed clear for a hold time given in clock cycles, computed as `BASE_CYC + STEP_CYC * hold_sel`. The hold count is taken from a register, and each timer copies that register when its hold starts. Each alert has its own timer. Each alert also has an open-drain pull-down enable, so that outputs from several blocks can be wire-ORed. A bypass input removes the hold delay.

Top module: `fault_alert_hold`

## Requirements
- R1: When any bit of `uv_flags` is 1, `uv_alert_n` is 0 in the same cycle.
- R2: Let edge k be the first rising edge at which `uv_flags` is all zero, with `bypass` low. The output `uv_alert_n` stays 0 through edge k+H-1 and is 1 after edge k+H, where H = BASE_CYC + STEP_CYC * hold_sel.
- R3: If a voltage fault reappears during the hold, the hold is abandoned. A full H cycles is counted again from the next edge at which all flags are clear.
- R4: With `ot_mode` = 1 and `temp_in > temp_limit`, `t2_alert_n` is 0 in the same cycle.
- R5: The temperature hold starts only when `temp_in + temp_hyst < temp_limit`. While the reading stays in the band between that point and the limit, the alert stays low indefinitely. A reading in that band during a hold does not restart the hold; only `temp_in > temp_limit` restarts it.
- R6: With `bypass` = 1 and no fault present at an edge, an asserted alert is 1 right after that edge.
- R7: With `ot_mode` = 0, `t2_alert_n` never newly goes low. A held temperature alert then releases H cycles after the mode falls.
- R8: Each `*_pd_en` output is always the inverse of its `*_alert_n` output (1 = pull-down on).
- R9: During and right after reset, both alerts are 1, both pull-down enables are 0, and both timers are idle.
- R10: The two timers are independent. A held undervoltage alert does not change the temperature release time.
- R11: `hold_sel` is registered. A change of `hold_sel` during a running hold does not change that hold's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flags | input | NCH | Per-channel under-threshold flags, 1 = below threshold |
| temp_in | input | TW | Temperature reading, unsigned |
| temp_limit | input | TW | Overtemperature limit |
| temp_hyst | input | TW | Hysteresis below the limit for release |
| ot_mode | input | 1 | 1 = second alert reports overtemperature |
| bypass | input | 1 | 1 = release without hold delay |
| hold_sel | input | SEL_W | Hold time step count |
| uv_alert_n | output | 1 | Undervoltage alert, active low |
| uv_pd_en | output | 1 | Pull-down enable for undervoltage alert |
| t2_alert_n | output | 1 | Temperature alert, active low |
| t2_pd_en | output | 1 | Pull-down enable for temperature alert |

## Verification
The bench builds the block with three voltage channels, 4-bit temperature values, a 2-bit `hold_sel`, BASE_CYC = 3 and STEP_CYC = 2, so hold times run from 3 to 9 cycles. This size lets the bench sweep every channel against every `hold_sel` value and every hysteresis from 0 to 3, and count each release to the exact edge. It also lets the bench place restarts, in-band readings and `hold_sel` changes inside a running hold.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_WAIT = 2'd1,
        TMR_HOLD = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/hold_count_reg.sv
module hold_count_reg #(
    parameter int SEL_W    = 4,
    parameter int BASE_CYC = 500,
    parameter int STEP_CYC = 8000,
    parameter int CW       = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] hold_sel,
    output logic [CW-1:0]    hold_cyc
);
    typedef struct packed {
        logic [CW-1:0] cyc;
    } hold_s;

    hold_s cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.cyc = CW'(BASE_CYC) + CW'(STEP_CYC) * CW'(hold_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{cyc: CW'(BASE_CYC)};
        else        cur_q <= nxt_d;
    end

    assign hold_cyc = cur_q.cyc;
endmodule

// File: rtl/temp_window.sv
module temp_window #(
    parameter int TW = 8
) (
    input  logic          enable,
    input  logic [TW-1:0] temp_in,
    input  logic [TW-1:0] temp_limit,
    input  logic [TW-1:0] temp_hyst,
    output logic          hot,
    output logic          cool
);
    logic [TW:0] t_ext, lim_ext, sum_ext;

    always_comb begin
        t_ext   = {1'b0, temp_in};
        lim_ext = {1'b0, temp_limit};
        sum_ext = t_ext + {1'b0, temp_hyst};
        hot     = enable && (t_ext > lim_ext);
        cool    = !enable || (sum_ext < lim_ext);
    end
endmodule

// File: rtl/alert_hold_timer.sv
module alert_hold_timer
    import fault_alert_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic          good_i,
    input  logic          bypass_i,
    input  logic [CW-1:0] hold_cyc_i,
    output logic          alert_o
);
    typedef struct packed {
        tmr_state_e    st;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            TMR_IDLE: begin
                if (fault_i) nxt_d.st = TMR_WAIT;
            end
            TMR_WAIT: begin
                if (good_i && !fault_i) begin
                    if (bypass_i) begin
                        nxt_d.st = TMR_IDLE;
                    end else begin
                        nxt_d.st  = TMR_HOLD;
                        nxt_d.cnt = hold_cyc_i;
                    end
                end
            end
            TMR_HOLD: begin
                if (fault_i) begin
                    nxt_d.st  = TMR_WAIT;
                    nxt_d.cnt = '0;
                end else if (bypass_i || cur_q.cnt <= CW'(1)) begin
                    nxt_d.st  = TMR_IDLE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CW'(1);
                end
            end
            default: begin
                nxt_d.st  = TMR_IDLE;
                nxt_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: TMR_IDLE, cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign alert_o = (cur_q.st != TMR_IDLE) || fault_i;
endmodule

// File: rtl/fault_alert_hold.sv
module fault_alert_hold #(
    parameter int NCH      = 4,
    parameter int TW       = 8,
    parameter int SEL_W    = 4,
    parameter int BASE_CYC = 500,
    parameter int STEP_CYC = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   uv_flags,
    input  logic [TW-1:0]    temp_in,
    input  logic [TW-1:0]    temp_limit,
    input  logic [TW-1:0]    temp_hyst,
    input  logic             ot_mode,
    input  logic             bypass,
    input  logic [SEL_W-1:0] hold_sel,
    output logic             uv_alert_n,
    output logic             uv_pd_en,
    output logic             t2_alert_n,
    output logic             t2_pd_en
);
    localparam int MAX_HOLD = BASE_CYC + STEP_CYC * ((1 << SEL_W) - 1);
    localparam int CW       = $clog2(MAX_HOLD + 1);
    localparam int NALERT   = 2;

    logic [CW-1:0]     hold_cyc;
    logic              t_hot, t_cool;
    logic [NALERT-1:0] fault_v, good_v, alert_v;

    hold_count_reg #(
        .SEL_W(SEL_W), .BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .CW(CW)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .hold_cyc(hold_cyc)
    );

    temp_window #(.TW(TW)) u_twin (
        .enable(ot_mode), .temp_in(temp_in), .temp_limit(temp_limit),
        .temp_hyst(temp_hyst), .hot(t_hot), .cool(t_cool)
    );

    always_comb begin
        fault_v[0] = |uv_flags;
        good_v[0]  = ~|uv_flags;
        fault_v[1] = t_hot;
        good_v[1]  = t_cool;
    end

    for (genvar g = 0; g < NALERT; g++) begin : g_tmr
        alert_hold_timer #(.CW(CW)) u_tmr (
            .clk(clk), .rst_n(rst_n), .fault_i(fault_v[g]), .good_i(good_v[g]),
            .bypass_i(bypass), .hold_cyc_i(hold_cyc), .alert_o(alert_v[g])
        );
    end

    assign uv_alert_n = !alert_v[0];
    assign uv_pd_en   = alert_v[0];
    assign t2_alert_n = !alert_v[1];
    assign t2_pd_en   = alert_v[1];
endmodule

// File: rtl/fault_alert_hold_chk.sv
module fault_alert_hold_chk #(
    parameter int NCH = 4,
    parameter int TW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] uv_flags,
    input logic [TW-1:0]  temp_in,
    input logic [TW-1:0]  temp_limit,
    input logic           ot_mode,
    input logic           bypass,
    input logic           uv_alert_n,
    input logic           uv_pd_en,
    input logic           t2_alert_n,
    input logic           t2_pd_en
);
    a_r1_uv_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_flags) |-> !uv_alert_n);

    a_r2_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_alert_n) |-> ($past(uv_flags) == '0));

    a_r4_ot_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_mode && (temp_in > temp_limit)) |-> !t2_alert_n);

    a_r5_no_release_while_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t2_alert_n) |-> !($past(ot_mode) && ($past(temp_in) > $past(temp_limit))));

    a_r6_bypass_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && (uv_flags == '0)) |=> ((uv_flags != '0) || uv_alert_n));

    a_r7_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ot_mode && $past(!ot_mode) && $past(t2_alert_n)) |-> t2_alert_n);

    a_r8_pd_uv: assert property (@(posedge clk) disable iff (!rst_n)
        uv_pd_en == !uv_alert_n);

    a_r8_pd_t2: assert property (@(posedge clk) disable iff (!rst_n)
        t2_pd_en == !t2_alert_n);
endmodule

bind fault_alert_hold fault_alert_hold_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .uv_flags(uv_flags), .temp_in(temp_in),
    .temp_limit(temp_limit), .ot_mode(ot_mode), .bypass(bypass),
    .uv_alert_n(uv_alert_n), .uv_pd_en(uv_pd_en),
    .t2_alert_n(t2_alert_n), .t2_pd_en(t2_pd_en)
);

// File: tb/fault_alert_hold_test.sv
module fault_alert_hold_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3, TW = 4, SEL_W = 2, BASE = 3, STEP = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   uv_flags = '0;
    logic [TW-1:0]    temp_in = '0, temp_limit = 4'd8, temp_hyst = '0;
    logic             ot_mode = 1'b0, bypass = 1'b0;
    logic [SEL_W-1:0] hold_sel = '0;
    logic             uv_alert_n, uv_pd_en, t2_alert_n, t2_pd_en;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_alert_hold #(.NCH(NCH), .TW(TW), .SEL_W(SEL_W), .BASE_CYC(BASE), .STEP_CYC(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .uv_flags(uv_flags), .temp_in(temp_in),
        .temp_limit(temp_limit), .temp_hyst(temp_hyst), .ot_mode(ot_mode),
        .bypass(bypass), .hold_sel(hold_sel), .uv_alert_n(uv_alert_n),
        .uv_pd_en(uv_pd_en), .t2_alert_n(t2_alert_n), .t2_pd_en(t2_pd_en)
    );

    function automatic int hold_of(input int s);
        return BASE + STEP * s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pd(input string req);
        chk(uv_pd_en == !uv_alert_n, req, uv_pd_en, !uv_alert_n);
        chk(t2_pd_en == !t2_alert_n, req, t2_pd_en, !t2_alert_n);
    endtask

    // counts edges until the chosen alert is high; kind 1 changes hold_sel, kind 2 puts temp in band
    task automatic measure(input bit t2, input int poke_at, input int kind, input int val, output int n);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1; n++;
            if (t2 ? t2_alert_n : uv_alert_n) break;
            if (n == poke_at) begin
                @(negedge clk);
                if (kind == 1) hold_sel = SEL_W'(val);
                else temp_in = TW'(val);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        #(CLK_PERIOD * 2 + 1);
        // R9 reset state
        chk(uv_alert_n && t2_alert_n, "R9 alerts high in reset", {uv_alert_n, t2_alert_n}, 3);
        chk(!uv_pd_en && !t2_pd_en, "R9 pd off in reset", {uv_pd_en, t2_pd_en}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        chk(uv_alert_n && t2_alert_n, "R9 idle after reset", {uv_alert_n, t2_alert_n}, 3);

        // R1 R2 R8 sweep channels x hold_sel
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); hold_sel = SEL_W'(s);
            repeat (2) @(posedge clk);
            for (int c = 0; c < NCH; c++) begin
                @(negedge clk); uv_flags = NCH'(1 << c); #1;
                chk(!uv_alert_n, "R1 immediate assert", uv_alert_n, 0);
                chk_pd("R8 pd inverse");
                @(negedge clk); uv_flags = '0;
                measure(0, -1, 0, 0, n);
                chk(n == hold_of(s) + 1, "R2 release time", n, hold_of(s) + 1);
            end
        end

        // R3 restart during hold
        @(negedge clk); hold_sel = 2'd2;
        repeat (2) @(posedge clk);
        @(negedge clk); uv_flags = 3'b010;
        @(negedge clk); uv_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); uv_flags = 3'b100; #1;
        chk(!uv_alert_n, "R3 refault low", uv_alert_n, 0);
        @(negedge clk); uv_flags = '0;
        measure(0, -1, 0, 0, n);
        chk(n == hold_of(2) + 1, "R3 full hold after restart", n, hold_of(2) + 1);

        // R11 hold_sel change mid hold
        @(negedge clk); hold_sel = 2'd3;
        repeat (2) @(posedge clk);
        @(negedge clk); uv_flags = 3'b001;
        @(negedge clk); uv_flags = '0;
        measure(0, 2, 1, 0, n);
        chk(n == hold_of(3) + 1, "R11 hold keeps loaded length", n, hold_of(3) + 1);
        repeat (2) @(posedge clk);
        @(negedge clk); uv_flags = 3'b001;
        @(negedge clk); uv_flags = '0;
        measure(0, -1, 0, 0, n);
        chk(n == hold_of(0) + 1, "R11 new value used next hold", n, hold_of(0) + 1);

        // R4 R5 temperature sweep over hysteresis
        @(negedge clk); hold_sel = 2'd1; ot_mode = 1'b1; temp_limit = 4'd8;
        repeat (2) @(posedge clk);
        for (int h = 0; h < 4; h++) begin
            @(negedge clk); temp_hyst = TW'(h); temp_in = 4'd9; #1;
            chk(!t2_alert_n, "R4 overtemp immediate", t2_alert_n, 0);
            chk_pd("R8 pd inverse t2");
            @(negedge clk); temp_in = TW'(8 - h);
            repeat (15) @(posedge clk); #1;
            chk(!t2_alert_n, "R5 band holds alert", t2_alert_n, 0);
            @(negedge clk); temp_in = TW'(7 - h);
            measure(1, -1, 0, 0, n);
            chk(n == hold_of(1) + 1, "R5 release after hysteresis", n, hold_of(1) + 1);
        end
        // R5 band reading during hold does not restart
        @(negedge clk); temp_hyst = 4'd2; temp_in = 4'd10;
        @(negedge clk); temp_in = 4'd3;
        measure(1, 2, 2, 8, n);
        chk(n == hold_of(1) + 1, "R5 band in hold no restart", n, hold_of(1) + 1);
        // R5 over-limit during hold restarts
        @(negedge clk); temp_in = 4'd10;
        @(negedge clk); temp_in = 4'd3;
        repeat (2) @(posedge clk);
        @(negedge clk); temp_in = 4'd9;
        @(negedge clk); temp_in = 4'd3;
        measure(1, -1, 0, 0, n);
        chk(n == hold_of(1) + 1, "R5 hot restarts hold", n, hold_of(1) + 1);

        // R10 independence: uv held while t2 releases
        @(negedge clk); uv_flags = 3'b100; temp_in = 4'd12;
        @(negedge clk); temp_in = 4'd2;
        measure(1, -1, 0, 0, n);
        chk(n == hold_of(1) + 1, "R10 t2 unaffected by uv", n, hold_of(1) + 1);
        chk(!uv_alert_n, "R10 uv still held", uv_alert_n, 0);
        @(negedge clk); uv_flags = '0;
        measure(0, -1, 0, 0, n);
        chk(n == hold_of(1) + 1, "R10 uv own hold", n, hold_of(1) + 1);

        // R7 mode low
        @(negedge clk); ot_mode = 1'b0; temp_in = 4'd15; #1;
        chk(t2_alert_n, "R7 mode low no assert", t2_alert_n, 1);
        repeat (4) @(posedge clk); #1;
        chk(t2_alert_n, "R7 mode low stays high", t2_alert_n, 1);
        @(negedge clk); ot_mode = 1'b1; #1;
        chk(!t2_alert_n, "R4 mode high hot asserts", t2_alert_n, 0);
        @(negedge clk); ot_mode = 1'b0;
        measure(1, -1, 0, 0, n);
        chk(n == hold_of(1) + 1, "R7 release after mode off", n, hold_of(1) + 1);

        // R6 bypass
        @(negedge clk); ot_mode = 1'b1; temp_in = 4'd2; bypass = 1'b1;
        @(negedge clk); uv_flags = 3'b011; #1;
        chk(!uv_alert_n, "R6 bypass still asserts", uv_alert_n, 0);
        @(negedge clk); uv_flags = '0;
        measure(0, -1, 0, 0, n);
        chk(n == 1, "R6 bypass uv release", n, 1);
        @(negedge clk); temp_in = 4'd11;
        @(negedge clk); temp_in = 4'd1;
        measure(1, -1, 0, 0, n);
        chk(n == 1, "R6 bypass t2 release", n, 1);
        // R6 bypass raised during a hold
        @(negedge clk); bypass = 1'b0; uv_flags = 3'b001;
        @(negedge clk); uv_flags = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); bypass = 1'b1;
        @(posedge clk); #1;
        chk(uv_alert_n, "R6 bypass ends running hold", uv_alert_n, 1);
        chk_pd("R8 pd inverse end");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule